// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

This block is one timer/counter channel driven through a small word-wide register port. Software loads a reload value and sets the run and interrupt enable bits in the control register. The channel then counts down from the reload value. When the count passes from 1 to 0, it loads the reload value again, sets an overflow flag and, if interrupts are enabled, marks an interrupt as pending on the `irq` output.

The block has two variants, chosen by a parameter. The timer variant has a 12-bit count that advances once every (timebase + 1) clock cycles. The counter variant has a 32-bit count that advances on every clock cycle. A pending interrupt is acknowledged by writing zero to the control register and then writing the earlier control value back. Reading the status register clears the overflow flag.

Register map (`addr`): 0 control, 1 reload, 2 live count (read only), 3 status, 4 interrupt pending (read only), 5 timebase. Other addresses read zero and ignore writes. Registers are written on a clock edge with `wr_en` set. `rdata` always shows the register selected by `addr`.

Top module: `tick_reload_timer`

## Requirements
- R1: After reset, control, reload, live count, timebase, status and interrupt pending all read zero, and `irq` is low.
- R2: The reload register keeps only the low 12 bits of a write in the timer variant (the low 32 bits in the counter variant). Reading it returns the stored value, so writing 0x1234 reads back as 0x234.
- R3: The control register holds three bits: bit 0 interrupt enable, bit 1 timer run, bit 2 counter run. They read back as written. In the timer variant only bit 1 makes the channel count.
- R4: A control write that turns the run bit on while it is off loads the live count from the reload register on that edge and restarts the prescaler.
- R5: In the timer variant the count decrements once every (timebase + 1) cycles. With timebase 2 and reload 3, `irq` rises 9 cycles after the arming write.
- R6: When the count passes from 1 to 0, it takes the reload value instead and status bit 0 (overflow) is set.
- R7: Reading the status register clears the overflow flag, unless a new expiry happens in the same cycle.
- R8: An expiry sets interrupt pending (register 4, bit 0, mirrored on `irq`) only while control bit 0 is set. With bit 0 clear, `irq` stays low but overflow is still set.
- R9: A control write with bit 0 clear removes the pending interrupt. Writing the earlier control value back restarts counting from the reload value.
- R10: A reload value of zero leaves the count at zero and never sets overflow or pending.
- R11: While the run bit is clear, and during any cycle in which control is written, the live count does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of status clears overflow |
| addr | input | 3 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Interrupt pending |

## Verification
The assertions assume that `wr_en`, `rd_en`, `addr` and `wdata` are known and stable around every rising edge, and that control is changed only through writes to address 0. The bench changes inputs one time unit after each rising edge and holds them for the whole cycle. During the random phase it chooses addresses only from the six mapped registers. Write values are kept mostly small so that expiries occur often, with occasional full-width words to exercise reload masking.

// File: rtl/tick_reload_timer.sv
module tick_reload_timer #(
  parameter bit TIMER_MODE = 1'b1,
  parameter int TB_W       = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int CW      = TIMER_MODE ? 12 : 32;
  localparam int RUN_BIT = TIMER_MODE ? 1 : 2;

  localparam logic [2:0] A_CTRL = 3'd0, A_RELOAD = 3'd1, A_VALUE = 3'd2,
                         A_STAT = 3'd3, A_PEND = 3'd4, A_TBASE = 3'd5;

  logic [2:0]      ctrl_q;
  logic [CW-1:0]   reload_q, cnt_q;
  logic [TB_W-1:0] tb_q, ps_q;
  logic            ovf_q, pend_q, tick;
  logic            unused_wdata;

  assign unused_wdata = ^wdata;

  wire ctrl_wr = wr_en && addr == A_CTRL;
  wire run_cur = ctrl_q[RUN_BIT];
  wire start   = ctrl_wr && wdata[RUN_BIT] && !run_cur;
  wire advance = run_cur && !ctrl_wr && tick;
  wire expire  = advance && cnt_q == CW'(1);

  generate
    if (TIMER_MODE) begin : g_prescale
      assign tick = ps_q >= tb_q;
      always_ff @(posedge clk) begin
        if (!rst_n || !run_cur || ctrl_wr || tick) ps_q <= '0;
        else                                       ps_q <= ps_q + 1'b1;
      end
    end else begin : g_direct
      assign tick = 1'b1;
      always_ff @(posedge clk) ps_q <= '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      tb_q     <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:   ctrl_q   <= wdata[2:0];
        A_RELOAD: reload_q <= wdata[CW-1:0];
        A_TBASE:  tb_q     <= wdata[TB_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (start)                    cnt_q <= reload_q;
    else if (expire)                   cnt_q <= reload_q;
    else if (advance && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                ovf_q <= 1'b0;
    else if (expire)                           ovf_q <= 1'b1;
    else if (rd_en && addr == A_STAT)          ovf_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      pend_q <= 1'b0;
    else if (ctrl_wr && !wdata[0])   pend_q <= 1'b0;
    else if (expire && ctrl_q[0])    pend_q <= 1'b1;
  end

  assign irq = pend_q;

  always_comb begin
    case (addr)
      A_CTRL:   rdata = 32'(ctrl_q);
      A_RELOAD: rdata = 32'(reload_q);
      A_VALUE:  rdata = 32'(cnt_q);
      A_STAT:   rdata = 32'(ovf_q);
      A_PEND:   rdata = 32'(pend_q);
      A_TBASE:  rdata = 32'(tb_q);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_reload_timer_chk.sv
module tick_reload_timer_chk #(
  parameter int CW      = 12,
  parameter int RUN_BIT = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [2:0]    addr,
  input logic [31:0]   wdata,
  input logic [2:0]    ctrl_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] reload_q,
  input logic          ovf_q,
  input logic          expire,
  input logic          irq
);
  wire ctrl_wr = wr_en && addr == 3'd0;

  p_expire_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt_q == $past(reload_q) && ovf_q));

  p_status_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd3 && !expire) |=> !ovf_q);

  p_irq_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[0]);

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[0]) |=> !irq);

  p_zero_stuck_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !ctrl_wr) |=> cnt_q == '0);

  p_hold_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[RUN_BIT] && !ctrl_wr) |=> $stable(cnt_q));
endmodule

bind tick_reload_timer tick_reload_timer_chk #(.CW(CW), .RUN_BIT(RUN_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .ctrl_q(ctrl_q), .cnt_q(cnt_q), .reload_q(reload_q),
  .ovf_q(ovf_q), .expire(expire), .irq(irq)
);

// File: tb/tick_reload_timer_test.sv
`timescale 1ns/1ps
module tick_reload_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0;
  int errors  = 0;

  int m_ctrl, m_reload, m_cnt, m_tb, m_ps;
  bit m_ovf, m_pend;

  always #2 clk = ~clk;

  tick_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic int model_read(input int a);
    case (a)
      0: return m_ctrl;
      1: return m_reload;
      2: return m_cnt;
      3: return int'(m_ovf);
      4: return int'(m_pend);
      5: return m_tb;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_reload = 0; m_cnt = 0; m_tb = 0; m_ps = 0;
      m_ovf = 0; m_pend = 0;
    end else begin
      bit cw, run, adv, nov, npend;
      int ncnt, nps;
      cw    = wr_en && addr == 3'd0;
      run   = m_ctrl[1];
      adv   = run && !cw && (m_ps >= m_tb);
      nps   = (!run || cw || m_ps >= m_tb) ? 0 : m_ps + 1;
      ncnt  = m_cnt;
      nov   = m_ovf;
      npend = m_pend;
      if (rd_en && addr == 3'd3) nov = 0;
      if (cw && !wdata[0]) npend = 0;
      if (cw && wdata[1] && !run) ncnt = m_reload;
      else if (adv && m_cnt != 0) begin
        if (m_cnt == 1) begin
          ncnt = m_reload;
          nov = 1;
          if (m_ctrl[0]) npend = 1;
        end else ncnt = m_cnt - 1;
      end
      if (wr_en) begin
        case (addr)
          3'd0: m_ctrl = int'(wdata & 32'h7);
          3'd1: m_reload = int'(wdata & 32'hfff);
          3'd5: m_tb = int'(wdata & 32'hffff);
          default: ;
        endcase
      end
      m_cnt = ncnt; m_ps = nps; m_ovf = nov; m_pend = npend;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (rdata !== 32'(model_read(int'(addr))) || irq !== m_pend) begin
        errors++;
        $display("FAIL model R6/R8 addr=%0d: rdata=%h irq=%b expected rdata=%h irq=%b",
                 addr, rdata, irq, model_read(int'(addr)), m_pend);
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = 3'(a); wdata = 32'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(posedge clk); #1;
    rd_en = 1'b1; addr = 3'(a);
    @(negedge clk);
    v = int'(rdata);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 100) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int v, n;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(0, v); chk("R1 ctrl", v, 0);
    rd(2, v); chk("R1 value", v, 0);
    rd(3, v); chk("R1 status", v, 0);
    rd(5, v); chk("R1 timebase", v, 0);
    chk("R1 irq", int'(irq), 0);

    wr(1, 32'h1234);
    rd(1, v); chk("R2 reload mask", v, 32'h234);

    wr(1, 3); wr(5, 2); wr(0, 3);
    wait_irq(n); chk("R5 cycles to irq", n, 9);
    rd(3, v); chk("R6 overflow set", v, 1);
    rd(3, v); chk("R7 overflow cleared", v, 0);
    rd(0, v); chk("R3 ctrl readback", v, 3);

    wr(0, 0);
    chk("R9 ack clears irq", int'(irq), 0);
    rd(2, v);
    begin
      int v2;
      repeat (7) @(posedge clk);
      rd(2, v2); chk("R11 stopped count holds", v2, v);
    end
    wr(0, 3);
    wait_irq(n); chk("R9 resume to irq", n, 9);

    wr(0, 0); wr(0, 2);
    repeat (30) @(posedge clk);
    #1 chk("R8 no irq without enable", int'(irq), 0);
    rd(3, v); chk("R8 overflow without irq", v, 1);

    wr(0, 0); wr(1, 0); rd(3, v); wr(0, 3);
    repeat (40) @(posedge clk);
    rd(2, v); chk("R10 count stays zero", v, 0);
    rd(3, v); chk("R10 no overflow", v, 0);
    chk("R10 no irq", int'(irq), 0);

    wr(0, 0); wr(1, 5); wr(0, 4);
    rd(2, v); chk("R3 counter bit does not run timer", v, 0);
    rd(0, v); chk("R3 ctrl bit2 readback", v, 4);
    wr(0, 6);
    rd(2, v); chk("R4 start loads reload", v, 5);

    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      wr_en = ($urandom % 10) < 3;
      rd_en = ($urandom % 10) < 3;
      addr  = 3'($urandom % 6);
      wdata = ($urandom % 10 == 0) ? $urandom : ($urandom % 16);
    end
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule